// File: doc/BRIEF.md
# I2C Sample-Enable and SCL Timing Generator

This block produces the timing base for an I2C controller. A reference clock is divided in two cascaded stages. The first stage is a small prescaler. The second stage counts the prescaler's ticks and emits a one-cycle sample-enable strobe. The strobe repeats every (A+1)·(B+1) reference cycles, where A and B are two divider fields taken from a 16-bit configuration word. Software picks the field values that come closest to the wanted bus rate. This block only applies them.

The strobe drives a half-period counter. Every eleven strobes that counter toggles a free-running SCL square wave and pulses an SCL-phase tick, so one SCL period is always 22 strobes long. The SCL output is for observation; clock stretching and the bus protocol are handled elsewhere. When the controller is disabled, or when either divider field changes, every counter restarts from zero. This means a shortened strobe interval is never produced.

Top module: `i2c_enable_divider`

## Requirements
- R1: While reset is asserted, `en_strobe_o`, `scl_tick_o` and `scl_o` are all 0.
- R2: Divider A is read from configuration bits 15:14 and divider B from bits 13:8. The value of each field is used as (field+1).
- R3: With the controller enabled and the fields steady, consecutive strobes are exactly (A+1)·(B+1) reference cycles apart, and each strobe lasts one cycle.
- R4: A field value of 0 divides that stage by one. With A=0 and B=0 the strobe is high on every cycle.
- R5: After `ctrl_en_i` rises, the first strobe appears (A+1)·(B+1) cycles later, measured from the first clock edge that samples the enable high.
- R6: If either field changes while the controller is enabled, no strobe appears in the old interval. The next strobe comes (A'+1)·(B'+1)+1 cycles after the change is applied, using the new values.
- R7: While `ctrl_en_i` is 0, no strobe and no SCL tick is produced, and `scl_o` is 0 from the cycle after the enable falls.
- R8: After a restart, `scl_o` stays low for 11 strobe periods, then high for 11 strobe periods, and repeats. Each half period contains exactly 11 strobes.
- R9: `scl_tick_o` is high in exactly the cycles in which `scl_o` has just changed level, and each such cycle also carries a strobe.
- R10: Configuration bits outside the two fields have no effect. Changing them in the middle of an interval neither restarts nor shifts the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_en_i | input | 1 | Controller enable; low holds all counters at zero |
| cfg_word_i | input | 16 | Configuration word carrying both divider fields |
| en_strobe_o | output | 1 | One-cycle sample-enable strobe |
| scl_tick_o | output | 1 | Pulses on each SCL level change |
| scl_o | output | 1 | Free-running SCL square wave |

## Verification
The strobe interval is swept over every A value against B values 0 to 15 and 63. Because N=(A+1)·(B+1) repeats across different field pairs, this sweep separates a wrong field slice or a swapped stage from a correct product. Each run measures both the first interval after enable and one steady interval, which separates an off-by-one at restart from an off-by-one in the wrap. The SCL wave is observed at N=1 and N=6 to confirm the 11/11 split in cycles and in strobe counts. A field change in mid-count, a change to unrelated bits in mid-count, and a disable with A=B=0 check that restart happens on exactly the right events and on no others.

// File: rtl/i2c_enable_divider_pkg.sv
package i2c_enable_divider_pkg;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned DIVA_LSB = 14;
  localparam int unsigned DIVA_W   = 2;
  localparam int unsigned DIVB_LSB = 8;
  localparam int unsigned DIVB_W   = 6;
  localparam int unsigned SCL_HALF = 11;
endpackage

// File: rtl/i2c_div_cfg_watch.sv
module i2c_div_cfg_watch #(
  parameter int unsigned CFG_W    = 16,
  parameter int unsigned DIVA_LSB = 14,
  parameter int unsigned DIVA_W   = 2,
  parameter int unsigned DIVB_LSB = 8,
  parameter int unsigned DIVB_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_en_i,
  input  logic [CFG_W-1:0]  cfg_word_i,
  output logic [DIVA_W-1:0] diva_o,
  output logic [DIVB_W-1:0] divb_o,
  output logic              restart_o
);
  logic [DIVA_W-1:0] diva_new, diva_q;
  logic [DIVB_W-1:0] divb_new, divb_q;
  logic              changed;

  always_comb begin
    diva_new  = cfg_word_i[DIVA_LSB +: DIVA_W];
    divb_new  = cfg_word_i[DIVB_LSB +: DIVB_W];
    changed   = (diva_new != diva_q) || (divb_new != divb_q);
    restart_o = changed || !ctrl_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diva_q <= '0;
      divb_q <= '0;
    end else if (changed) begin
      diva_q <= diva_new;
      divb_q <= divb_new;
    end
  end

  assign diva_o = diva_q;
  assign divb_o = divb_q;

  // R2: held fields follow the configuration word one cycle later
  assert_fields_track_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (diva_q == $past(cfg_word_i[DIVA_LSB +: DIVA_W])) &&
             (divb_q == $past(cfg_word_i[DIVB_LSB +: DIVB_W])));
endmodule

// File: rtl/i2c_div_stage.sv
module i2c_div_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_limit;

  always_comb begin
    at_limit = (cnt_q == limit_i);
    wrap_o   = step_i && !restart_i && at_limit;
    cnt_d    = cnt_q;
    if (restart_i)         cnt_d = '0;
    else if (step_i)       cnt_d = at_limit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3: the count never passes the programmed limit
  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q <= limit_i);
  // R6: a restart always leaves the count at zero
  assert_restart_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase #(
  parameter int unsigned HALF = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic strobe_i,
  output logic tick_o,
  output logic scl_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] ph_q, ph_d;
  logic          scl_q, scl_d, tick_q, tick_d;
  logic          half_done;

  always_comb begin
    half_done = strobe_i && (ph_q == LAST);
    ph_d   = ph_q;
    scl_d  = scl_q;
    tick_d = 1'b0;
    if (restart_i) begin
      ph_d  = '0;
      scl_d = 1'b0;
    end else if (strobe_i) begin
      ph_d = half_done ? '0 : ph_q + 1'b1;
      if (half_done) begin
        scl_d  = !scl_q;
        tick_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      scl_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      scl_q  <= scl_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
  assign scl_o  = scl_q;

  // R8: the half-period count stays below HALF
  assert_phase_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST);
  // R9: SCL only rises together with a tick
  assert_rise_has_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_q) |-> tick_q);
endmodule

// File: rtl/i2c_enable_divider.sv
module i2c_enable_divider
  import i2c_enable_divider_pkg::*;
#(
  parameter int unsigned CW      = CFG_W,
  parameter int unsigned A_LSB   = DIVA_LSB,
  parameter int unsigned A_W     = DIVA_W,
  parameter int unsigned B_LSB   = DIVB_LSB,
  parameter int unsigned B_W     = DIVB_W,
  parameter int unsigned HALF_SC = SCL_HALF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_en_i,
  input  logic [CW-1:0] cfg_word_i,
  output logic          en_strobe_o,
  output logic          scl_tick_o,
  output logic          scl_o
);
  logic [A_W-1:0] diva;
  logic [B_W-1:0] divb;
  logic           restart, pre_tick, en_comb;
  logic           en_q, en_d;

  i2c_div_cfg_watch #(
    .CFG_W(CW), .DIVA_LSB(A_LSB), .DIVA_W(A_W), .DIVB_LSB(B_LSB), .DIVB_W(B_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_en_i(ctrl_en_i), .cfg_word_i(cfg_word_i),
    .diva_o(diva), .divb_o(divb), .restart_o(restart)
  );

  i2c_div_stage #(.W(A_W)) u_stage_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .step_i(1'b1),
    .limit_i(diva), .wrap_o(pre_tick)
  );

  i2c_div_stage #(.W(B_W)) u_stage_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .step_i(pre_tick),
    .limit_i(divb), .wrap_o(en_comb)
  );

  i2c_scl_phase #(.HALF(HALF_SC)) u_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart), .strobe_i(en_comb),
    .tick_o(scl_tick_o), .scl_o(scl_o)
  );

  always_comb en_d = en_comb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d;
  end

  assign en_strobe_o = en_q;

  // R7: a disabled controller yields no strobe on the next cycle
  assert_quiet_when_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i |=> !en_strobe_o);
  // R3: strobes are single-cycle unless both stages divide by one
  assert_no_back_to_back_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_strobe_o && !restart && (diva != '0 || divb != '0)) |=> !en_strobe_o);
  // R9: each SCL tick sits on a strobe
  assert_tick_on_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_tick_o |-> en_strobe_o);
endmodule

// File: tb/i2c_enable_divider_test.sv
module i2c_enable_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        en_strobe, scl_tick, scl;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  i2c_enable_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(ctrl_en), .cfg_word_i(cfg),
    .en_strobe_o(en_strobe), .scl_tick_o(scl_tick), .scl_o(scl)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic gap_to_strobe(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!en_strobe && g < 5000);
  endtask

  task automatic restart_with(input int a, input int b, input logic [7:0] low);
    @(negedge clk);
    ctrl_en = 1'b0;
    cfg = {a[1:0], b[5:0], low};
    @(negedge clk);
    ctrl_en = 1'b1;
  endtask

  task automatic scl_run(input int a, input int b);
    int n, g, s;
    n = (a + 1) * (b + 1);
    restart_with(a, b, 8'h00);
    g = 0; s = 0;
    do begin @(negedge clk); g++; if (en_strobe) s++; end while (!scl && g < 20000);
    check(g == 11 * n, "R8 low half length", g, 11 * n);
    check(s == 11, "R8 strobes in low half", s, 11);
    check(scl_tick == 1'b1, "R9 tick at rise", scl_tick, 1);
    g = 0; s = 0;
    do begin
      @(negedge clk); g++; if (en_strobe) s++;
      if (scl && scl_tick) check(1'b0, "R9 tick without edge", 1, 0);
    end while (scl && g < 20000);
    check(g == 11 * n, "R8 high half length", g, 11 * n);
    check(s == 11, "R8 strobes in high half", s, 11);
    check(scl_tick == 1'b1, "R9 tick at fall", scl_tick, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int g, n, bv, seen;
    repeat (3) begin
      @(negedge clk);
      check(!en_strobe && !scl_tick && !scl, "R1 reset outputs", {en_strobe, scl_tick, scl}, 0);
    end
    rst_n = 1'b1;

    // R2 R3 R4 R5: sweep of all A with B 0..15 and 63
    for (int a = 0; a < 4; a++) begin
      for (int bi = 0; bi < 17; bi++) begin
        bv = (bi == 16) ? 63 : bi;
        n = (a + 1) * (bv + 1);
        restart_with(a, bv, 8'h5A);
        gap_to_strobe(g);
        check(g == n, $sformatf("R5 first strobe A=%0d B=%0d", a, bv), g, n);
        gap_to_strobe(g);
        check(g == n, $sformatf("R3 R2 interval A=%0d B=%0d", a, bv), g, n);
        if (n == 1) begin
          @(negedge clk);
          check(en_strobe == 1'b1, "R4 strobe every cycle", en_strobe, 1);
        end
      end
    end

    // R10: unrelated bits changed mid-interval
    restart_with(3, 63, 8'h00);
    repeat (100) @(negedge clk);
    cfg[7:0] = 8'hFF;
    g = 100;
    do begin @(negedge clk); g++; end while (!en_strobe && g < 5000);
    check(g == 256, "R10 low bits ignored", g, 256);

    // R6: field change mid-interval
    repeat (100) @(negedge clk);
    check(en_strobe == 1'b0, "R6 idle before change", en_strobe, 0);
    cfg[15:8] = {2'd1, 6'd1};
    gap_to_strobe(g);
    check(g == 5, "R6 restart on field change", g, 5);
    gap_to_strobe(g);
    check(g == 4, "R6 new interval", g, 4);

    // R7: disable with divide-by-one fields
    restart_with(0, 0, 8'h00);
    repeat (5) @(negedge clk);
    ctrl_en = 1'b0;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (en_strobe || scl_tick || scl) seen++;
    end
    check(seen == 0, "R7 quiet while disabled", seen, 0);

    // R8 R9: SCL shape
    scl_run(0, 0);
    scl_run(1, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule